// File: doc/BRIEF.md
# Single-Precision Square Root Unit

This unit takes one IEEE single-precision operand per issue and returns its square root with four per-operation flags: invalid, inexact, input flushed to zero and output flushed to zero. Results are rounded in one of four selectable directions. A digit-recurrence datapath retires two root bits per cycle. The result always appears a fixed 17 cycles after the issue edge. The unit accepts a new operation 16 cycles after the previous one, so two operations can overlap by one cycle.

Denormal operands are treated as zero of the same sign, and this is reported by a dedicated flag. Negative nonzero operands and NaN operands return the all-ones quiet NaN. A guard bit travels with each operation. When the guard is clear, the result-valid pulse still appears but the write enable and every flag stay low, so the surrounding register file and sticky status are left untouched. Issue requests made while the unit is busy are dropped.

Top module: `fsqrt_unit`

## Requirements
- R1: For a positive normal operand with rounding mode 00 (nearest, ties to even), the result is the correctly rounded root. Inexact is set exactly when the root is not representable. Examples: 0x40400000 gives 0x3FDDB3D7, 0x7F7FFFFF gives 0x5F7FFFFF and 0x00C00000 gives 0x201CC471, all with inexact set.
- R2: The rounding-mode input is encoded as 01 toward zero, 10 toward +infinity and 11 toward -infinity. A root that rounds up to 2.0 carries into the exponent.
- R3: An operand with exponent field 0 and a nonzero fraction returns zero with the operand's sign and sets the input-flushed flag. For example, 0x00400000 gives 0 and 0x80400000 gives 0x80000000.
- R4: An operand of +0 or -0 returns the same signed zero with no flag set.
- R5: A negative operand with nonzero magnitude, including -infinity, returns 0xFFFFFFFF and sets invalid.
- R6: A NaN operand returns 0xFFFFFFFF. Invalid is set only when fraction bit 22 is 0 (signaling NaN).
- R7: An operand of +infinity (0x7F800000) returns 0x7F800000 with no flag set.
- R8: The result-valid output pulses for exactly one cycle, 17 rising edges after the edge that accepts the issue. The result and flags are valid in that same cycle.
- R9: After an accepting edge, the busy output is high for the next 15 cycles. An issue seen while busy is high is dropped and produces no result. An issue 16 edges after the previous accept is taken.
- R10: With guard 1, write enable is asserted together with result-valid and the flags. With guard 0, write enable and all four flags stay 0.
- R11: The output-flushed flag is set, with the result forced to +0, only when the rounded exponent is zero. No operand reaches that case, so the flag stays 0.
- R12: After reset, valid, busy, write enable and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue request for the operand on op_i |
| op_i | input | 32 | Single-precision operand |
| guard_i | input | 1 | Guard; 1 commits result and flags |
| rmode_i | input | 2 | Rounding mode (00 near, 01 zero, 10 +inf, 11 -inf) |
| busy_o | output | 1 | High while issues are refused |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 32 | Root |
| wr_en_o | output | 1 | Result write enable |
| inv_o | output | 1 | Invalid flag |
| inx_o | output | 1 | Inexact flag |
| ifz_o | output | 1 | Input flushed to zero |
| ofz_o | output | 1 | Output flushed to zero |

## Verification
The hardest case to reach from the ports is two operations in flight at once. The second one is loaded into the recurrence while the first result still waits in the hold register. A directed sequence issues one operand, attempts a second inside the busy window, and then issues a third on the first allowed edge. It checks that the first result is intact, that the dropped request never produces a pulse, and that the third result lands 16 cycles after the first. Rounding-up carries into the exponent are reached by sweeping fraction values near all-ones in every exponent and every mode.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } rmode_e;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned SIG_W  = FRAC_W + 2;      // significand after odd-exponent shift
  localparam int unsigned ROOT_W = FRAC_W + 3;      // hidden + fraction + round + extra
  localparam int unsigned RAD_W  = 2 * ROOT_W;
  localparam int unsigned REM_W  = ROOT_W + 3;

  localparam logic [WORD_W-1:0] QNAN    = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] POS_INF = 32'h7F80_0000;
  localparam logic [EXP_W-1:0]  HALF_BIAS_LO = 8'd63;
endpackage

// File: rtl/fsqrt_classify.sv
module fsqrt_classify
  import fsqrt_pkg::*;
(
  input  logic [WORD_W-1:0] op_i,
  output logic              special_o,
  output logic [WORD_W-1:0] spec_res_o,
  output logic              spec_inv_o,
  output logic              ifz_o,
  output logic [EXP_W-1:0]  exp_res_o,
  output logic [RAD_W-1:0]  rad_o
);
  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [SIG_W-1:0]  sig_adj;

  always_comb begin
    sgn        = op_i[WORD_W-1];
    ex         = op_i[WORD_W-2 -: EXP_W];
    fr         = op_i[FRAC_W-1:0];
    special_o  = 1'b1;
    spec_res_o = QNAN;
    spec_inv_o = 1'b0;
    ifz_o      = 1'b0;
    if (ex == '1 && fr != '0) begin
      spec_inv_o = ~fr[FRAC_W-1];            // signaling NaN only
    end else if (ex == '0) begin
      spec_res_o = {sgn, {(WORD_W-1){1'b0}}};
      ifz_o      = (fr != '0);
    end else if (sgn) begin
      spec_inv_o = 1'b1;
    end else if (ex == '1) begin
      spec_res_o = POS_INF;
    end else begin
      special_o  = 1'b0;
    end
    // even biased exponent means odd unbiased: pre-shift significand
    sig_adj   = ex[0] ? {1'b0, 1'b1, fr} : {1'b1, fr, 1'b0};
    exp_res_o = {1'b0, ex[EXP_W-1:1]} + HALF_BIAS_LO + {{(EXP_W-1){1'b0}}, ex[0]};
    rad_o     = {sig_adj, {(RAD_W-SIG_W){1'b0}}};
  end
endmodule

// File: rtl/fsqrt_recur.sv
module fsqrt_recur
  import fsqrt_pkg::*;
#(
  parameter int unsigned ITER = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [RAD_W-1:0]  rad_i,
  output logic [ROOT_W-1:0] q_o,
  output logic              rem_nz_o
);
  logic [REM_W-1:0]  rem_q;
  logic [ROOT_W-1:0] q_q;
  logic [RAD_W-1:0]  rad_q;

  logic [REM_W-1:0]  r_c [ITER+1];
  logic [ROOT_W-1:0] q_c [ITER+1];
  logic [RAD_W-1:0]  d_c [ITER+1];

  assign r_c[0] = rem_q;
  assign q_c[0] = q_q;
  assign d_c[0] = rad_q;

  for (genvar k = 0; k < ITER; k++) begin : g_step
    logic [REM_W-1:0] cur;
    logic [REM_W-1:0] trial;
    logic             ge;
    assign cur      = {r_c[k][REM_W-3:0], d_c[k][RAD_W-1 -: 2]};
    assign trial    = {{(REM_W-ROOT_W-2){1'b0}}, q_c[k], 2'b01};
    assign ge       = (cur >= trial);
    assign r_c[k+1] = ge ? cur - trial : cur;
    assign q_c[k+1] = {q_c[k][ROOT_W-2:0], ge};
    assign d_c[k+1] = {d_c[k][RAD_W-3:0], 2'b00};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      q_q   <= '0;
      rad_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      q_q   <= '0;
      rad_q <= rad_i;
    end else if (step_i) begin
      rem_q <= r_c[ITER];
      q_q   <= q_c[ITER];
      rad_q <= d_c[ITER];
    end
  end

  assign q_o      = q_q;
  assign rem_nz_o = (rem_q != '0);
endmodule

// File: rtl/fsqrt_round.sv
module fsqrt_round
  import fsqrt_pkg::*;
(
  input  logic [ROOT_W-1:0] q_i,
  input  logic              rem_nz_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  rmode_e            rm_i,
  output logic [WORD_W-1:0] res_o,
  output logic              inx_o,
  output logic              ofz_o
);
  logic             rnd, stk, lsb, inc;
  logic [FRAC_W+1:0] sum;
  logic [EXP_W-1:0] exp_n;

  always_comb begin
    rnd = q_i[1];
    stk = q_i[0] | rem_nz_i;
    lsb = q_i[2];
    unique case (rm_i)
      RM_NEAR: inc = rnd & (stk | lsb);
      RM_POS:  inc = rnd | stk;          // root is never negative
      default: inc = 1'b0;
    endcase
    sum   = {1'b0, q_i[ROOT_W-1:2]} + {{(FRAC_W+1){1'b0}}, inc};
    exp_n = exp_i + {{(EXP_W-1){1'b0}}, sum[FRAC_W+1]};
    inx_o = rnd | stk;
    ofz_o = (exp_n == '0);
    res_o = ofz_o ? '0 : {1'b0, exp_n, sum[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fsqrt_unit.sv
module fsqrt_unit
  import fsqrt_pkg::*;
#(
  parameter int unsigned ITER_PER_CYC = 2,
  parameter int unsigned LATENCY      = 17,
  parameter int unsigned ISSUE_GAP    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [WORD_W-1:0] op_i,
  input  logic              guard_i,
  input  logic [1:0]        rmode_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [WORD_W-1:0] result_o,
  output logic              wr_en_o,
  output logic              inv_o,
  output logic              inx_o,
  output logic              ifz_o,
  output logic              ofz_o
);
  localparam int unsigned STEP_CYC = ROOT_W / ITER_PER_CYC;
  localparam int unsigned FIN      = ISSUE_GAP - 1;
  localparam int unsigned OUT_DLY  = LATENCY - FIN;
  localparam int unsigned CW       = $clog2(ISSUE_GAP + 1);
  localparam int unsigned OW       = $clog2(OUT_DLY + 1);

  logic [CW-1:0] ctr_q;
  logic [OW-1:0] out_cnt_q;
  logic          accept, step, fin, emit;

  assign busy_o = (ctr_q != '0);
  assign accept = issue_i & ~busy_o;
  assign step   = (ctr_q >= CW'(1)) && (ctr_q <= CW'(STEP_CYC));
  assign fin    = (ctr_q == CW'(FIN));
  assign emit   = (out_cnt_q == OW'(OUT_DLY));

  // front end
  logic              c_special, c_inv, c_ifz;
  logic [WORD_W-1:0] c_res;
  logic [EXP_W-1:0]  c_exp;
  logic [RAD_W-1:0]  c_rad;

  fsqrt_classify u_cls (
    .op_i      (op_i),
    .special_o (c_special),
    .spec_res_o(c_res),
    .spec_inv_o(c_inv),
    .ifz_o     (c_ifz),
    .exp_res_o (c_exp),
    .rad_o     (c_rad)
  );

  logic              spec_q, sinv_q, sifz_q, guard_q;
  logic [WORD_W-1:0] sres_q;
  logic [EXP_W-1:0]  exp_q;
  rmode_e            rm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_q  <= 1'b0;
      sinv_q  <= 1'b0;
      sifz_q  <= 1'b0;
      guard_q <= 1'b0;
      sres_q  <= '0;
      exp_q   <= '0;
      rm_q    <= RM_NEAR;
    end else if (accept) begin
      spec_q  <= c_special;
      sinv_q  <= c_inv;
      sifz_q  <= c_ifz;
      guard_q <= guard_i;
      sres_q  <= c_res;
      exp_q   <= c_exp;
      rm_q    <= rmode_e'(rmode_i);
    end
  end

  logic [ROOT_W-1:0] root;
  logic              rem_nz;

  fsqrt_recur #(.ITER(ITER_PER_CYC)) u_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .step_i  (step),
    .rad_i   (c_rad),
    .q_o     (root),
    .rem_nz_o(rem_nz)
  );

  logic [WORD_W-1:0] r_res;
  logic              r_inx, r_ofz;

  fsqrt_round u_rnd (
    .q_i     (root),
    .rem_nz_i(rem_nz),
    .exp_i   (exp_q),
    .rm_i    (rm_q),
    .res_o   (r_res),
    .inx_o   (r_inx),
    .ofz_o   (r_ofz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q <= '0;
    end else if (accept) begin
      ctr_q <= CW'(1);
    end else if (fin) begin
      ctr_q <= '0;
    end else if (busy_o) begin
      ctr_q <= ctr_q + CW'(1);
    end
  end

  // hold stage frees the recurrence for the next issue
  logic              h_g, h_inv, h_inx, h_ifz, h_ofz;
  logic [WORD_W-1:0] h_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_g <= 1'b0; h_inv <= 1'b0; h_inx <= 1'b0; h_ifz <= 1'b0; h_ofz <= 1'b0;
      h_res <= '0;
      out_cnt_q <= '0;
    end else begin
      if (fin) begin
        h_g   <= guard_q;
        h_res <= spec_q ? sres_q : r_res;
        h_inv <= spec_q & sinv_q;
        h_ifz <= spec_q & sifz_q;
        h_inx <= ~spec_q & r_inx;
        h_ofz <= ~spec_q & r_ofz;
      end
      if (fin)                    out_cnt_q <= OW'(1);
      else if (emit)              out_cnt_q <= '0;
      else if (out_cnt_q != '0)   out_cnt_q <= out_cnt_q + OW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      wr_en_o  <= 1'b0;
      inv_o    <= 1'b0;
      inx_o    <= 1'b0;
      ifz_o    <= 1'b0;
      ofz_o    <= 1'b0;
    end else begin
      valid_o <= emit;
      wr_en_o <= emit & h_g;
      inv_o   <= emit & h_g & h_inv;
      inx_o   <= emit & h_g & h_inx;
      ifz_o   <= emit & h_g & h_ifz;
      ofz_o   <= emit & h_g & h_ofz;
      if (emit) result_o <= h_res;
    end
  end
endmodule

// File: rtl/fsqrt_unit_chk.sv
module fsqrt_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        issue_i,
  input logic [31:0] op_i,
  input logic        guard_i,
  input logic [1:0]  rmode_i,
  input logic        busy_o,
  input logic        valid_o,
  input logic [31:0] result_o,
  input logic        wr_en_o,
  input logic        inv_o,
  input logic        inx_o,
  input logic        ifz_o,
  input logic        ofz_o
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R8
  AST_WREN_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);  // R10
  AST_FLAGS_WITH_WREN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_o | inx_o | ifz_o | ofz_o) |-> wr_en_o);  // R10
  AST_INV_GIVES_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> (result_o == 32'hFFFF_FFFF));  // R5
  AST_IFZ_GIVES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifz_o |-> (result_o[30:0] == 31'd0));  // R3
  AST_NO_OFZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ofz_o);  // R11
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !busy_o) |=> busy_o);  // R9
  AST_INX_NOT_SPECIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inx_o |-> !(inv_o || ifz_o));  // R1
endmodule

bind fsqrt_unit fsqrt_unit_chk u_chk (.*);

// File: tb/sim_fsqrt_unit.sv
module sim_fsqrt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [31:0] op = '0;
  logic        guard = 1'b1;
  logic [1:0]  rmode = 2'b00;
  logic        busy, valid, wr_en, inv, inx, ifz, ofz;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fsqrt_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op), .guard_i(guard),
    .rmode_i(rmode), .busy_o(busy), .valid_o(valid), .result_o(result),
    .wr_en_o(wr_en), .inv_o(inv), .inx_o(inx), .ifz_o(ifz), .ofz_o(ofz)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint v);
    longint lo = 0, hi = 64'd1 << 26, mid;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= v) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  // expected root and flags {inv,inx,ifz}
  function automatic logic [34:0] model(input logic [31:0] x, input logic [1:0] rm);
    logic s = x[31];
    int   e = int'(x[30:23]);
    logic [22:0] f = x[22:0];
    longint sig, r24, m;
    int eadj, re;
    bit odd, exact, above, up;
    logic [31:0] r;
    if (e == 255 && f != 0) return {32'hFFFF_FFFF, ~f[22], 1'b0, 1'b0};
    if (e == 0)              return {s, 31'd0, 1'b0, 1'b0, (f != 0)};
    if (s)                   return {32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0};
    if (e == 255)            return {32'h7F80_0000, 3'b000};
    odd  = ((e % 2) == 0);
    sig  = (64'd1 << 23) + longint'(f);
    if (odd) sig = sig * 2;
    eadj = (e - 127) - (odd ? 1 : 0);
    re   = eadj / 2 + 127;
    r24  = sig << 23;
    m    = isqrt(r24);
    exact = (m * m == r24);
    above = (4 * r24 > (2 * m + 1) * (2 * m + 1));
    case (rm)
      2'b00: up = above;
      2'b10: up = !exact;
      default: up = 1'b0;
    endcase
    if (up) m = m + 1;
    if (m == (64'd1 << 24)) begin m = 64'd1 << 23; re = re + 1; end
    r = {1'b0, 8'(re), 23'(m)};
    return {r, 1'b0, !exact, 1'b0};
  endfunction

  logic [31:0] last_res;

  task automatic issue_one(input logic [31:0] x, input logic g, input logic [1:0] rm);
    @(negedge clk);
    issue = 1'b1; op = x; guard = g; rmode = rm;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic run_op(input logic [31:0] x, input logic g, input logic [1:0] rm, input string req);
    logic [34:0] e;
    logic [3:0]  fe, fa;
    bit ok;
    issue_one(x, g, rm);
    for (int i = 1; i < 17; i++) @(negedge clk);
    check(valid == 1'b0, "R8 early", 64'(valid), 64'd0);
    @(negedge clk);
    e  = model(x, rm);
    fe = g ? {e[2], e[1], e[0], 1'b0} : 4'b0000;
    fa = {inv, inx, ifz, ofz};
    ok = valid && (result == e[34:3]) && (wr_en == g) && (fa == fe);
    check(ok, req, {valid, wr_en, fa, 26'd0, result}, {1'b1, g, fe, 26'd0, e[34:3]});
    last_res = result;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [22:0] fr;
    repeat (3) @(negedge clk);
    check({valid, busy, wr_en, inv, inx, ifz, ofz} == 7'd0, "R12 in reset",
          64'({valid, busy, wr_en, inv, inx, ifz, ofz}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({valid, busy, wr_en, inv, inx, ifz, ofz} == 7'd0, "R12 after reset",
          64'({valid, busy, wr_en, inv, inx, ifz, ofz}), 64'd0);

    // R1 fixed vectors
    run_op(32'h4040_0000, 1'b1, 2'b00, "R1 sqrt3");
    check(last_res == 32'h3FDD_B3D7, "R1 sqrt3 literal", 64'(last_res), 64'h3FDD_B3D7);
    run_op(32'h7F7F_FFFF, 1'b1, 2'b00, "R1 max");
    check(last_res == 32'h5F7F_FFFF, "R1 max literal", 64'(last_res), 64'h5F7F_FFFF);
    run_op(32'h00C0_0000, 1'b1, 2'b00, "R1 small");
    check(last_res == 32'h201C_C471, "R1 small literal", 64'(last_res), 64'h201C_C471);
    run_op(32'h4080_0000, 1'b1, 2'b00, "R1 exact four");
    // R2 carry into exponent: largest significand, odd shift
    run_op(32'h407F_FFFF, 1'b1, 2'b10, "R2 up carry");
    run_op(32'h407F_FFFF, 1'b1, 2'b01, "R2 toward zero");
    run_op(32'h407F_FFFF, 1'b1, 2'b11, "R2 toward minus");
    // R3..R7 specials
    run_op(32'h0040_0000, 1'b1, 2'b00, "R3 pos denormal");
    run_op(32'h8040_0000, 1'b1, 2'b00, "R3 neg denormal");
    run_op(32'h0000_0001, 1'b1, 2'b10, "R3 tiny denormal");
    run_op(32'h0000_0000, 1'b1, 2'b00, "R4 pos zero");
    run_op(32'h8000_0000, 1'b1, 2'b00, "R4 neg zero");
    run_op(32'hC040_0000, 1'b1, 2'b00, "R5 neg normal");
    run_op(32'hFF80_0000, 1'b1, 2'b00, "R5 neg inf");
    run_op(32'h7FC0_0000, 1'b1, 2'b00, "R6 quiet nan");
    run_op(32'h7F80_0001, 1'b1, 2'b00, "R6 signaling nan");
    run_op(32'hFFC0_0001, 1'b1, 2'b00, "R6 neg quiet nan");
    run_op(32'h7F80_0000, 1'b1, 2'b00, "R7 pos inf");
    // R10 guard off
    run_op(32'hC040_0000, 1'b0, 2'b00, "R10 guard off invalid");
    run_op(32'h4040_0000, 1'b0, 2'b00, "R10 guard off inexact");
    run_op(32'h0040_0000, 1'b0, 2'b00, "R10 guard off flushed");

    // R9 busy window, dropped issue, overlap at minimum interval
    @(negedge clk);
    issue = 1'b1; op = 32'h4080_0000; guard = 1'b1; rmode = 2'b00;
    @(negedge clk);                     // after accept edge 0
    issue = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    for (int i = 1; i < 5; i++) @(negedge clk);
    issue = 1'b1; op = 32'h4110_0000;   // edge 5: must be dropped
    @(negedge clk);
    issue = 1'b0;
    for (int i = 6; i < 15; i++) @(negedge clk);
    check(busy == 1'b1, "R9 busy at 14", 64'(busy), 64'd1);
    @(negedge clk);                     // after edge 15
    check(busy == 1'b0, "R9 free at 15", 64'(busy), 64'd0);
    issue = 1'b1; op = 32'h4180_0000;   // edge 16
    @(negedge clk);
    issue = 1'b0;
    check(valid == 1'b0, "R8 no pulse at 16", 64'(valid), 64'd0);
    @(negedge clk);                     // after edge 17
    check(valid && result == 32'h4000_0000, "R9 first result intact",
          {31'd0, valid, result}, {31'd0, 1'b1, 32'h4000_0000});
    begin
      int pulses = 0;
      for (int i = 18; i < 33; i++) begin
        @(negedge clk);
        if (valid) pulses++;
      end
      check(pulses == 0, "R9 dropped issue silent", 64'(pulses), 64'd0);
    end
    @(negedge clk);                     // after edge 33
    check(valid && result == 32'h4080_0000, "R9 overlapped result",
          {31'd0, valid, result}, {31'd0, 1'b1, 32'h4080_0000});

    // R1/R2/R11 sweep over exponents, fractions and modes
    for (int e = 1; e < 255; e++) begin
      for (int j = 0; j < 6; j++) begin
        case (j)
          0: fr = 23'h000000;
          1: fr = 23'h7FFFFF;
          2: fr = 23'h400000;
          3: fr = 23'h123457;
          4: fr = 23'h7FFFFE;
          default: fr = 23'((e * 40503 + 12345) * 97);
        endcase
        for (int m = 0; m < 4; m++)
          run_op({1'b0, 8'(e), fr}, 1'b1, 2'(m), (m == 0) ? "R1 sweep" : "R2 sweep R11");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule